// File: doc/BRIEF.md
# Serial Register Slave with Frame Checks

This block is the serial control port of an eight-channel switch controller. A host sends 16-bit commands over a four-wire serial link: one read/write bit, a seven-bit register address and a data byte, all MSB first. Writes land in a small byte-wide register map. One of its registers drives the switch-control output. Reads return the addressed register on the serial output, after a fixed alignment byte.

Three independently enabled checks protect the link. An optional CRC-8 byte extends every command to 24 bits and guards writes. A clock-count check flags frames whose edge count is wrong. An address check flags unknown registers and writes to the read-only flag register. A fixed command word clears the flags. Burst mode lets several commands share one chip-select window. A two-step key sequence restores every register to its reset value.

The serial inputs are oversampled by the system clock `clk`. They are assumed to be already synchronous to it and to hold each level for at least two `clk` cycles. The serial output is open-drain: `sdo_pd` = 1 means the line is pulled low, otherwise it is released and reads as 1 through the external pull-up.

Top module: `swspi_slave`

## Requirements
- R1: Data bits are taken from `sdi` on `sclk` rising edges while `cs_n` is low. The first bit is R/W (0 = write, 1 = read), then the address, then the data byte, all MSB first. With CRC off, a write lands on rising edge 16, and `sw_data` follows the register at address 0x01.
- R2: Bit 0 of the response appears when `cs_n` falls, and falling edge k presents bit k. Bits 0..7 are 0x25. For reads, bits 8..15 are the addressed register as sampled on rising edge 8. For writes, those bits are released (1). While `cs_n` is high, `sdo_pd` is 0.
- R3: The map is 0x01 switch data, 0x02 check configuration, 0x03 flags (read-only), 0x05 burst enable (bit 0) and 0x0B reset key. An unknown address, or a write to 0x03, sets flag bit 2 on rising edge 9 when configuration bit 2 is 1, and changes no register. When configuration bit 2 is 0, no flag is set.
- R4: With configuration bit 1 set and burst off, a frame whose rising-edge count differs from the command length sets flag bit 1 when `cs_n` rises. A short frame writes nothing. A long frame still writes on its final command edge.
- R5: The write word 0x6CA9 (address 0x6C, data 0xA9) clears all flags when the command completes. With CRC on, it must also carry a valid CRC. It never raises the address flag.
- R6: With configuration bit 0 set at `cs_n` fall, commands are 24 bits. A write lands on edge 24 only if the received byte equals CRC-8 (polynomial 0x07, seed 0, MSB first) of the 16 command bits. Otherwise nothing is written and flag bit 0 is set.
- R7: In CRC mode, read response bits 16..23 carry the CRC-8 of {1, address, returned data byte}.
- R8: Burst enable, sampled at `cs_n` fall, lets commands run back to back in one frame, each with its own response. The count check then passes only for a nonzero multiple of the command length.
- R9: A write of 0xA3 to 0x0B, followed by a write of 0x05 to 0x0B as the next completed command, returns all registers to reset values. Any command in between cancels the key.
- R10: Synchronous reset `rst` sets switch data 0x00, configuration 0x06, flags 0x00 and burst 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low frame select |
| sdi | input | 1 | Serial data from the host |
| sdo_pd | output | 1 | 1 = pull the open-drain data output low |
| sdo_bit | output | 1 | Response bit currently presented |
| sw_data | output | 8 | Switch-control register contents |

## Verification
The bench targets the edges where a command's fate is decided. It sends a 12-edge frame, which must leave the switches unchanged, and a 20-edge frame, which must still write but raise the count flag. It writes the read-only flag register, and it sends a CRC byte with one bit flipped. A design that commits too early, or that never gates on the check result, shows up as a changed `sw_data` or as a missing flag on the readback. In burst frames it checks that the second command's response starts with a fresh alignment byte. It also checks that 40 edges count as an error. The reset key is first interrupted by a read, which must cancel it, and then sent cleanly, which must restore the defaults. Read CRC bytes are compared with a CRC computed in the bench.

// File: rtl/swspi_pkg.sv
package swspi_pkg;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 8;
  localparam int CRC_W  = 8;
  localparam int CMD_W  = 1 + ADDR_W + DATA_W;

  localparam logic [ADDR_W-1:0] A_SW    = 7'h01;
  localparam logic [ADDR_W-1:0] A_CFG   = 7'h02;
  localparam logic [ADDR_W-1:0] A_FLG   = 7'h03;
  localparam logic [ADDR_W-1:0] A_BURST = 7'h05;
  localparam logic [ADDR_W-1:0] A_SRST  = 7'h0B;

  localparam logic [CMD_W-1:0]  CLR_WORD = 16'h6CA9;
  localparam logic [ADDR_W-1:0] A_CLR    = CLR_WORD[CMD_W-2 -: ADDR_W];
  localparam logic [DATA_W-1:0] CLR_KEY  = CLR_WORD[DATA_W-1:0];

  localparam logic [DATA_W-1:0] ALIGN     = 8'h25;
  localparam logic [DATA_W-1:0] CFG_RST   = 8'h06;
  localparam logic [DATA_W-1:0] SRST_KEY0 = 8'hA3;
  localparam logic [DATA_W-1:0] SRST_KEY1 = 8'h05;
  localparam logic [CRC_W-1:0]  CRC_POLY  = 8'h07;

  localparam int F_CRC  = 0;
  localparam int F_SCLK = 1;
  localparam int F_ADDR = 2;
  localparam int NFLAGS = 3;
endpackage

// File: rtl/swspi_frame.sv
module swspi_frame
  import swspi_pkg::*;
#(
  parameter int CW = CMD_W,
  parameter int KW = CRC_W,
  parameter int DW = DATA_W,
  parameter int PW = $clog2(CW + KW + 2)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sclk,
  input  logic          cs_n,
  input  logic          sdi,
  input  logic          crc_en,
  input  logic          burst_en,
  output logic          rise,
  output logic          fall,
  output logic          cs_fall,
  output logic          cs_rise,
  output logic          crc_mode,
  output logic          burst_mode,
  output logic [PW-1:0] pos,
  output logic [PW-1:0] edge_no,
  output logic          last,
  output logic          count_err,
  output logic [DW-1:0] byte_in
);
  logic          sclk_q, cs_q, extra, any;
  logic [DW-1:0] sh;
  logic [PW-1:0] len;

  assign rise     = sclk & ~sclk_q & ~cs_n;
  assign fall     = ~sclk & sclk_q & ~cs_n;
  assign cs_fall  = ~cs_n & cs_q;
  assign cs_rise  = cs_n & ~cs_q;
  assign len      = crc_mode ? PW'(CW + KW) : PW'(CW);
  assign edge_no  = pos + 1'b1;
  assign last     = rise && (edge_no == len);
  assign byte_in  = {sh[DW-2:0], sdi};
  assign count_err = burst_mode ? ((pos != '0) || !any) : ((pos != len) || extra);

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q     <= 1'b0;
      cs_q       <= 1'b1;
      crc_mode   <= 1'b0;
      burst_mode <= 1'b0;
      pos        <= '0;
      extra      <= 1'b0;
      any        <= 1'b0;
      sh         <= '0;
    end else begin
      sclk_q <= sclk;
      cs_q   <= cs_n;
      if (cs_fall) begin
        crc_mode   <= crc_en;
        burst_mode <= burst_en;
        pos        <= '0;
        extra      <= 1'b0;
        any        <= 1'b0;
      end else if (rise) begin
        any <= 1'b1;
        sh  <= byte_in;
        if (pos == len) extra <= 1'b1;
        else if (burst_mode && (edge_no == len)) pos <= '0;
        else pos <= edge_no;
      end
    end
  end
endmodule

// File: rtl/swspi_crc8.sv
module swspi_crc8
  import swspi_pkg::*;
#(
  parameter int              KW   = CRC_W,
  parameter logic [KW-1:0]   POLY = CRC_POLY
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          first,
  input  logic          din,
  output logic [KW-1:0] crc,
  output logic [KW-1:0] crc_nxt
);
  logic [KW-1:0] base;

  assign base    = first ? '0 : crc;
  assign crc_nxt = {base[KW-2:0], 1'b0} ^ ((base[KW-1] ^ din) ? POLY : '0);

  always_ff @(posedge clk) begin
    if (rst) crc <= '0;
    else if (en) crc <= crc_nxt;
  end
endmodule

// File: rtl/swspi_regfile.sv
module swspi_regfile
  import swspi_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int NF = NFLAGS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          done,
  input  logic          wr_ok,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [NF-1:0] set_flags,
  output logic [DW-1:0] sw,
  output logic [DW-1:0] cfg,
  output logic [DW-1:0] flg,
  output logic          burst
);
  logic armed;
  logic key_hit;

  assign key_hit = done && wr_ok && (addr == A_SRST) && armed && (wdata == SRST_KEY1);

  always_ff @(posedge clk) begin
    if (rst || key_hit) begin
      sw    <= '0;
      cfg   <= CFG_RST;
      flg   <= '0;
      burst <= 1'b0;
      armed <= 1'b0;
    end else begin
      flg <= flg | DW'(set_flags);
      if (done) begin
        armed <= wr_ok && (addr == A_SRST) && (wdata == SRST_KEY0);
        if (wr_ok) begin
          case (addr)
            A_SW:    sw    <= wdata;
            A_CFG:   cfg   <= wdata;
            A_BURST: burst <= wdata[0];
            A_CLR:   if (wdata == CLR_KEY) flg <= '0;
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/swspi_slave.sv
module swspi_slave
  import swspi_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int KW = CRC_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sclk,
  input  logic          cs_n,
  input  logic          sdi,
  output logic          sdo_pd,
  output logic          sdo_bit,
  output logic [DW-1:0] sw_data
);
  localparam int CW    = 1 + AW + DW;
  localparam int FW    = CW + KW;
  localparam int PW    = $clog2(FW + 2);
  localparam int E_HDR = AW + 1;
  localparam int E_CHK = AW + 2;

  logic          rise, fall, cs_fall, cs_rise, crc_mode, burst_mode, last, count_err;
  logic [PW-1:0] pos, edge_no;
  logic [DW-1:0] byte_in, dat, cfg_q, flg_q;
  logic [AW:0]   hdr;
  logic          burst_q, is_rd, addr_bad, crc_din, crc_match, wr_ok;
  logic          at_hdr, at_chk, at_dat, set_rw, set_crc, set_sclk;
  logic [KW-1:0] crc, crc_nxt;
  logic [FW-1:0] tx;
  logic [DW-1:0] wr_data;

  swspi_frame #(.CW(CW), .KW(KW), .DW(DW), .PW(PW)) u_frame (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
    .crc_en(cfg_q[F_CRC]), .burst_en(burst_q),
    .rise(rise), .fall(fall), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .crc_mode(crc_mode), .burst_mode(burst_mode), .pos(pos), .edge_no(edge_no),
    .last(last), .count_err(count_err), .byte_in(byte_in)
  );

  function automatic logic [DW-1:0] rd_mux(input logic [AW-1:0] a);
    case (a)
      A_SW:    return sw_data;
      A_CFG:   return cfg_q;
      A_FLG:   return flg_q;
      A_BURST: return DW'(burst_q);
      default: return '0;
    endcase
  endfunction

  assign is_rd  = hdr[AW];
  assign at_hdr = rise && (edge_no == PW'(E_HDR));
  assign at_chk = rise && (edge_no == PW'(E_CHK));
  assign at_dat = rise && (edge_no == PW'(CW));

  always_comb begin
    case (hdr[AW-1:0])
      A_SW, A_CFG, A_BURST, A_SRST: addr_bad = 1'b0;
      A_FLG:   addr_bad = ~is_rd;
      default: addr_bad = ~(~is_rd && (hdr[AW-1:0] == A_CLR));
    endcase
  end

  // read CRC covers the bits actually presented on the output
  assign crc_din = (is_rd && (pos >= PW'(E_HDR))) ? sdo_bit : sdi;

  swspi_crc8 #(.KW(KW)) u_crc (
    .clk(clk), .rst(rst), .en(rise && (pos < PW'(CW))), .first(pos == '0),
    .din(crc_din), .crc(crc), .crc_nxt(crc_nxt)
  );

  assign crc_match = (byte_in[KW-1:0] == crc);
  assign wr_ok     = ~is_rd && (~crc_mode || crc_match);
  assign wr_data   = crc_mode ? dat : byte_in;
  assign set_rw    = at_chk && cfg_q[F_ADDR] && addr_bad;
  assign set_crc   = last && crc_mode && ~is_rd && ~crc_match;
  assign set_sclk  = cs_rise && cfg_q[F_SCLK] && count_err;

  swspi_regfile #(.AW(AW), .DW(DW), .NF(NFLAGS)) u_regs (
    .clk(clk), .rst(rst), .done(last), .wr_ok(wr_ok), .addr(hdr[AW-1:0]),
    .wdata(wr_data), .set_flags({set_rw, set_sclk, set_crc}),
    .sw(sw_data), .cfg(cfg_q), .flg(flg_q), .burst(burst_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hdr     <= '0;
      dat     <= '0;
      tx      <= '1;
      sdo_bit <= 1'b1;
    end else begin
      if (at_hdr) hdr <= byte_in[AW:0];
      if (at_dat) dat <= byte_in;
      if (cs_fall) begin
        sdo_bit <= ALIGN[DW-1];
        tx      <= {ALIGN[DW-2:0], {(FW-DW+1){1'b1}}};
      end else if (cs_rise) begin
        sdo_bit <= 1'b1;
        tx      <= '1;
      end else if (fall) begin
        sdo_bit <= tx[FW-1];
        tx      <= {tx[FW-2:0], 1'b1};
      end else if (rise) begin
        if (last)
          tx <= burst_mode ? {ALIGN, {(FW-DW){1'b1}}} : '1;
        else if (at_hdr && byte_in[AW])
          tx[FW-1 -: DW] <= rd_mux(byte_in[AW-1:0]);
        else if (at_dat && is_rd && crc_mode)
          tx[FW-1 -: KW] <= crc_nxt;
      end
    end
  end

  assign sdo_pd = ~u_frame.cs_q & ~sdo_bit;
endmodule

// File: rtl/swspi_checks.sv
module swspi_checks #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          cs_n,
  input logic          sdo_pd,
  input logic [DW-1:0] sw_data,
  input logic [DW-1:0] flg,
  input logic [DW-1:0] cfg,
  input logic          crc_mode
);
  p_sw_in_frame_r1: assert property (@(posedge clk) disable iff (rst)
    !$stable(sw_data) |-> !$past(cs_n));

  p_sdo_release_r2: assert property (@(posedge clk) disable iff (rst)
    (cs_n && $past(cs_n)) |-> !sdo_pd);

  p_addr_flag_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(flg[2]) |-> $past(cfg[2]));

  p_count_flag_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(flg[1]) |-> ($past(cs_n) && $past(cfg[1])));

  p_crc_flag_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(flg[0]) |-> $past(crc_mode));
endmodule

bind swspi_slave swspi_checks #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .sdo_pd(sdo_pd), .sw_data(sw_data),
  .flg(flg_q), .cfg(cfg_q), .crc_mode(crc_mode)
);

// File: tb/sim_swspi_slave.sv
module sim_swspi_slave;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1, sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0;
  logic sdo_pd, sdo_bit;
  logic [7:0] sw_data;
  int checks = 0, fails = 0;
  bit crc_on = 1'b0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  swspi_slave u0 (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
    .sdo_pd(sdo_pd), .sdo_bit(sdo_bit), .sw_data(sw_data)
  );

  function automatic logic [7:0] crc8w(input logic [15:0] w);
    logic [7:0] c = 8'h00;
    for (int i = 15; i >= 0; i--) begin
      logic fb = c[7] ^ w[i];
      c = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return c;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [63:0] w, input int n, output logic [63:0] got);
    got = '1;
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      sdi = w[63-i];
      repeat (2) @(negedge clk);
      got[63-i] = ~sdo_pd;
      sclk = 1'b1;
      repeat (2) @(negedge clk);
      sclk = 1'b0;
      repeat (2) @(negedge clk);
    end
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    logic [15:0] c = {1'b0, a, d};
    logic [63:0] g;
    if (crc_on) xfer({c, crc8w(c), 40'h0}, 24, g);
    else        xfer({c, 48'h0}, 16, g);
  endtask

  task automatic rd(input logic [6:0] a, output logic [7:0] al,
                    output logic [7:0] d, output logic [7:0] k);
    logic [15:0] c = {1'b1, a, 8'h00};
    logic [63:0] g;
    xfer({c, 48'h0}, crc_on ? 24 : 16, g);
    al = g[63:56];
    d  = g[55:48];
    k  = g[47:40];
  endtask

  initial begin
    logic [7:0] al, d, k;
    logic [63:0] g;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    chk("R10 sw_data after reset", sw_data, 8'h00);
    chk("R2 sdo released when idle", sdo_pd, 1'b0);
    rd(7'h02, al, d, k);
    chk("R2 alignment byte", al, 8'h25);
    chk("R10 config default", d, 8'h06);
    rd(7'h03, al, d, k); chk("R10 flags default", d, 8'h00);
    rd(7'h05, al, d, k); chk("R10 burst default", d, 8'h00);

    wr(7'h01, 8'h5A);
    chk("R1 write switch data", sw_data, 8'h5A);
    rd(7'h01, al, d, k);
    chk("R2 read switch data", d, 8'h5A);

    wr(7'h40, 8'h11);
    chk("R3 bad address leaves sw", sw_data, 8'h5A);
    rd(7'h03, al, d, k); chk("R3 bad address flag", d, 8'h04);
    wr(7'h6C, 8'hA9);
    rd(7'h03, al, d, k); chk("R5 clear flags", d, 8'h00);
    wr(7'h03, 8'hFF);
    rd(7'h03, al, d, k); chk("R3 read-only flags", d, 8'h04);
    wr(7'h6C, 8'hA9);
    wr(7'h02, 8'h02);
    wr(7'h40, 8'h11);
    rd(7'h03, al, d, k); chk("R3 address check disabled", d, 8'h00);
    wr(7'h02, 8'h06);

    xfer({16'h01C3, 48'h0}, 12, g);
    chk("R4 short frame no write", sw_data, 8'h5A);
    rd(7'h03, al, d, k); chk("R4 short frame flag", d, 8'h02);
    wr(7'h6C, 8'hA9);
    xfer({16'h0133, 48'h0}, 20, g);
    chk("R4 long frame still writes", sw_data, 8'h33);
    rd(7'h03, al, d, k); chk("R4 long frame flag", d, 8'h02);
    wr(7'h6C, 8'hA9);

    wr(7'h05, 8'h01);
    xfer({16'h0111, 16'h8200, 32'h0}, 32, g);
    chk("R2 write data slot released", g[55:48], 8'hFF);
    chk("R8 burst second alignment", g[47:40], 8'h25);
    chk("R8 burst second read data", g[39:32], 8'h06);
    chk("R8 burst first write", sw_data, 8'h11);
    rd(7'h03, al, d, k); chk("R8 burst count ok", d, 8'h00);
    xfer({16'h0122, 16'h0144, 8'h00, 24'h0}, 40, g);
    chk("R8 burst last write", sw_data, 8'h44);
    rd(7'h03, al, d, k); chk("R8 burst count error", d, 8'h02);
    wr(7'h6C, 8'hA9);
    wr(7'h05, 8'h00);

    wr(7'h02, 8'h07);
    crc_on = 1'b1;
    wr(7'h01, 8'h99);
    chk("R6 good crc write", sw_data, 8'h99);
    xfer({16'h0177, crc8w(16'h0177) ^ 8'h01, 40'h0}, 24, g);
    chk("R6 bad crc blocks write", sw_data, 8'h99);
    rd(7'h03, al, d, k); chk("R6 crc flag", d, 8'h01);
    rd(7'h01, al, d, k);
    chk("R7 crc read data", d, 8'h99);
    chk("R7 read crc byte", k, crc8w({1'b1, 7'h01, 8'h99}));
    wr(7'h6C, 8'hA9);
    rd(7'h03, al, d, k); chk("R5 clear with crc", d, 8'h00);

    wr(7'h0B, 8'hA3);
    rd(7'h01, al, d, k);
    wr(7'h0B, 8'h05);
    rd(7'h02, al, d, k); chk("R9 interrupted key ignored", d, 8'h07);
    wr(7'h0B, 8'hA3);
    wr(7'h0B, 8'h05);
    crc_on = 1'b0;
    rd(7'h02, al, d, k); chk("R9 soft reset config", d, 8'h06);
    chk("R9 soft reset switch data", sw_data, 8'h00);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule